// File: doc/BRIEF.md
# JTAG IDCODE Stream Separator

This block accepts the serial bit stream that a scan-chain controller captures from the data registers immediately after every TAP has been reset. It splits that stream into one entry per device. At reset, each TAP selects either its identification register or its single-bit bypass register. These two are told apart by the first bit that leaves them. A bypass register always shifts out a 0. An identification code always has a 1 in its least significant bit, and bits leave least significant first.

The separator frames the stream one device at a time. For each device it produces a one-cycle record. A record either marks a device without an identification code, or carries the assembled 32-bit code together with its version, part number, manufacturer bank and manufacturer ID fields. If the end-of-stream strobe arrives while a code is only partly assembled, the block produces a truncation error pulse instead of a record. Running counts of all records, of identified devices and of bypass devices are kept for the controller that drives the block.

Top module: `idcode_splitter`

## Requirements
- R1: After reset, `out_valid` and `out_trunc_err` are 0 and all three counts are 0.
- R2: With no code being assembled, an accepted 0 bit consumes exactly one bit. One clock edge later it produces a record with `out_valid`=1 and `out_has_idcode`=0.
- R3: With no code being assembled, an accepted 1 bit becomes bit 0 of a new code. The next 31 accepted bits fill bits 1 to 31 in arrival order. One clock edge after the 32nd bit, a record appears with `out_has_idcode`=1 and `out_idcode` equal to the assembled word, whose bit 0 is 1.
- R4: In a code record, `out_version` is code bits [31:28] and `out_part` is bits [27:12]. `out_bank` (the continuation bank, modulo 16) is bits [11:8] and `out_mfr_id` is bits [7:1].
- R5: Cycles with `bit_valid`=0 consume no bit, whatever the value on `bit_in`.
- R6: If `end_of_stream` is high while a code is unfinished, the error is raised one edge later. This applies after any bit accepted in that same cycle. `out_trunc_err` pulses for one cycle, no record is produced, and the next 1 bit starts a fresh code.
- R7: `end_of_stream` with no code in progress produces no output. If it arrives together with the 32nd bit of a code, only the normal record is produced.
- R8: `rec_count` increments once per record. `id_count` counts records with a code and `byp_count` counts records without one. Truncation errors change no count.
- R9: `out_valid` and `out_trunc_err` are single-cycle pulses per event and are never high together.
- R10: In a bypass record, `out_idcode` and all field outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | `bit_in` carries a stream bit this cycle |
| bit_in | input | 1 | Stream bit, least significant first |
| end_of_stream | input | 1 | Stream has ended (taken after any same-cycle bit) |
| out_valid | output | 1 | One-cycle record strobe |
| out_trunc_err | output | 1 | One-cycle truncated-code error strobe |
| out_has_idcode | output | 1 | Record carries an identification code |
| out_idcode | output | 32 | Assembled code (0 for bypass) |
| out_version | output | 4 | Version field |
| out_part | output | 16 | Part number field |
| out_bank | output | 4 | Manufacturer continuation bank modulo 16 |
| out_mfr_id | output | 7 | Manufacturer ID within the bank |
| rec_count | output | CNT_W | Records produced |
| id_count | output | CNT_W | Records with a code |
| byp_count | output | CNT_W | Records without a code |

## Verification
The stream mixes lone bypass bits with codes of differing shapes:
- an all-ones word, which shows that no bit is lost at the start or end of a frame;
- a word that is 1 only at its two ends, which exposes a bit order or offset error;
- ordinary codes, which check that every field lands in its slice.

Codes are sent both back to back and with idle cycles that carry noise on the data input, which separates true framing from raw bit counting.

Truncation is exercised in three ways: with the end strobe on its own cycle, with the strobe on the starting bit, and with the strobe on the final bit. These show whether the strobe is taken after the same-cycle bit. A following full code then confirms that framing restarts cleanly.

// File: rtl/idsplit_pkg.sv
package idsplit_pkg;

    localparam int ID_W     = 32;
    localparam int VER_W    = 4;
    localparam int PART_W   = 16;
    localparam int BANK_W   = 4;
    localparam int MFR_W    = 7;
    localparam int MFR_LSB  = 1;
    localparam int BANK_LSB = MFR_LSB + MFR_W;
    localparam int PART_LSB = BANK_LSB + BANK_W;
    localparam int VER_LSB  = PART_LSB + PART_W;

    typedef struct packed {
        logic [VER_W-1:0]  version;
        logic [PART_W-1:0] part;
        logic [BANK_W-1:0] bank;
        logic [MFR_W-1:0]  mfr;
    } id_fields_t;

    typedef struct packed {
        logic              has_id;
        logic [ID_W-1:0]   code;
        id_fields_t        fields;
    } dev_rec_t;

endpackage

// File: rtl/idsplit_framer.sv
module idsplit_framer
    import idsplit_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_valid,
    input  logic            bit_in,
    input  logic            end_of_stream,
    output logic            ev_bypass,
    output logic            ev_idcode,
    output logic            ev_trunc,
    output logic [ID_W-1:0] word
);

    localparam int CW = $clog2(ID_W);

    typedef struct packed {
        logic            collecting;
        logic [CW-1:0]   cnt;
        logic [ID_W-1:0] sreg;
    } frm_t;

    frm_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        ev_bypass = 1'b0;
        ev_idcode = 1'b0;
        ev_trunc  = 1'b0;
        word      = {bit_in, s_q.sreg[ID_W-1:1]};

        if (bit_valid) begin
            s_d.sreg = word;
            if (!s_q.collecting) begin
                if (bit_in) begin
                    s_d.collecting = 1'b1;
                    s_d.cnt        = CW'(1);
                end else begin
                    ev_bypass = 1'b1;
                end
            end else if (s_q.cnt == CW'(ID_W - 1)) begin
                ev_idcode      = 1'b1;
                s_d.collecting = 1'b0;
                s_d.cnt        = '0;
            end else begin
                s_d.cnt = s_q.cnt + CW'(1);
            end
        end

        if (end_of_stream && s_d.collecting) begin
            ev_trunc       = 1'b1;
            s_d.collecting = 1'b0;
            s_d.cnt        = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/idsplit_fields.sv
module idsplit_fields
    import idsplit_pkg::*;
(
    input  logic [ID_W-1:0] word,
    output id_fields_t      fields
);

    always_comb begin
        fields.version = word[VER_LSB  +: VER_W];
        fields.part    = word[PART_LSB +: PART_W];
        fields.bank    = word[BANK_LSB +: BANK_W];
        fields.mfr     = word[MFR_LSB  +: MFR_W];
    end

endmodule

// File: rtl/idsplit_tally.sv
module idsplit_tally #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_bypass,
    input  logic             ev_idcode,
    output logic [CNT_W-1:0] rec_count,
    output logic [CNT_W-1:0] id_count,
    output logic [CNT_W-1:0] byp_count
);

    typedef struct packed {
        logic [CNT_W-1:0] rec;
        logic [CNT_W-1:0] ids;
        logic [CNT_W-1:0] byp;
    } tally_t;

    tally_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (ev_idcode) begin
            t_d.ids = t_q.ids + CNT_W'(1);
        end
        if (ev_bypass) begin
            t_d.byp = t_q.byp + CNT_W'(1);
        end
        if (ev_idcode || ev_bypass) begin
            t_d.rec = t_q.rec + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign rec_count = t_q.rec;
    assign id_count  = t_q.ids;
    assign byp_count = t_q.byp;

endmodule

// File: rtl/idcode_splitter.sv
module idcode_splitter
    import idsplit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_valid,
    input  logic             bit_in,
    input  logic             end_of_stream,
    output logic             out_valid,
    output logic             out_trunc_err,
    output logic             out_has_idcode,
    output logic [31:0]      out_idcode,
    output logic [3:0]       out_version,
    output logic [15:0]      out_part,
    output logic [3:0]       out_bank,
    output logic [6:0]       out_mfr_id,
    output logic [CNT_W-1:0] rec_count,
    output logic [CNT_W-1:0] id_count,
    output logic [CNT_W-1:0] byp_count
);

    typedef struct packed {
        logic     valid;
        logic     trunc;
        dev_rec_t rec;
    } out_t;

    logic            ev_bypass;
    logic            ev_idcode;
    logic            ev_trunc;
    logic [ID_W-1:0] word;
    id_fields_t      fields;

    out_t o_d, o_q;

    idsplit_framer u_framer (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_valid     (bit_valid),
        .bit_in        (bit_in),
        .end_of_stream (end_of_stream),
        .ev_bypass     (ev_bypass),
        .ev_idcode     (ev_idcode),
        .ev_trunc      (ev_trunc),
        .word          (word)
    );

    idsplit_fields u_fields (
        .word   (word),
        .fields (fields)
    );

    idsplit_tally #(.CNT_W(CNT_W)) u_tally (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_bypass (ev_bypass),
        .ev_idcode (ev_idcode),
        .rec_count (rec_count),
        .id_count  (id_count),
        .byp_count (byp_count)
    );

    always_comb begin
        o_d            = '0;
        o_d.valid      = ev_idcode | ev_bypass;
        o_d.trunc      = ev_trunc;
        o_d.rec.has_id = ev_idcode;
        if (ev_idcode) begin
            o_d.rec.code   = word;
            o_d.rec.fields = fields;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_valid      = o_q.valid;
    assign out_trunc_err  = o_q.trunc;
    assign out_has_idcode = o_q.rec.has_id;
    assign out_idcode     = o_q.rec.code;
    assign out_version    = o_q.rec.fields.version;
    assign out_part       = o_q.rec.fields.part;
    assign out_bank       = o_q.rec.fields.bank;
    assign out_mfr_id     = o_q.rec.fields.mfr;

endmodule

// File: rtl/idsplit_checker.sv
module idsplit_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_valid,
    input logic             bit_in,
    input logic             end_of_stream,
    input logic             out_valid,
    input logic             out_trunc_err,
    input logic             out_has_idcode,
    input logic [31:0]      out_idcode,
    input logic [3:0]       out_version,
    input logic [15:0]      out_part,
    input logic [3:0]       out_bank,
    input logic [6:0]       out_mfr_id,
    input logic [CNT_W-1:0] rec_count,
    input logic [CNT_W-1:0] id_count,
    input logic [CNT_W-1:0] byp_count
);

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_trunc_err));

    assert_code_lsb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_has_idcode) |-> out_idcode[0]);

    assert_field_slices_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_has_idcode) |->
            (out_version == out_idcode[31:28] && out_part == out_idcode[27:12] &&
             out_bank == out_idcode[11:8] && out_mfr_id == out_idcode[7:1]));

    assert_bypass_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_has_idcode) |->
            (out_idcode == '0 && out_version == '0 && out_part == '0 &&
             out_bank == '0 && out_mfr_id == '0));

    assert_bypass_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_has_idcode) |-> $past(bit_valid && !bit_in));

    assert_trunc_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_trunc_err |-> $past(end_of_stream));

    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (rec_count - $past(rec_count) == CNT_W'(1)));

    assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(rec_count));

    assert_count_split_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rec_count == CNT_W'(id_count + byp_count));

endmodule

bind idcode_splitter idsplit_checker #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bit_valid      (bit_valid),
    .bit_in         (bit_in),
    .end_of_stream  (end_of_stream),
    .out_valid      (out_valid),
    .out_trunc_err  (out_trunc_err),
    .out_has_idcode (out_has_idcode),
    .out_idcode     (out_idcode),
    .out_version    (out_version),
    .out_part       (out_part),
    .out_bank       (out_bank),
    .out_mfr_id     (out_mfr_id),
    .rec_count      (rec_count),
    .id_count       (id_count),
    .byp_count      (byp_count)
);

// File: tb/idcode_splitter_test.sv
module idcode_splitter_test;

    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_valid = 1'b0;
    logic bit_in = 1'b0;
    logic end_of_stream = 1'b0;

    logic             out_valid, out_trunc_err, out_has_idcode;
    logic [31:0]      out_idcode;
    logic [3:0]       out_version, out_bank;
    logic [15:0]      out_part;
    logic [6:0]       out_mfr_id;
    logic [CNT_W-1:0] rec_count, id_count, byp_count;

    always #4 clk = ~clk;

    idcode_splitter #(.CNT_W(CNT_W)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .bit_valid      (bit_valid),
        .bit_in         (bit_in),
        .end_of_stream  (end_of_stream),
        .out_valid      (out_valid),
        .out_trunc_err  (out_trunc_err),
        .out_has_idcode (out_has_idcode),
        .out_idcode     (out_idcode),
        .out_version    (out_version),
        .out_part       (out_part),
        .out_bank       (out_bank),
        .out_mfr_id     (out_mfr_id),
        .rec_count      (rec_count),
        .id_count       (id_count),
        .byp_count      (byp_count)
    );

    typedef struct {
        int          kind;
        logic [31:0] code;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   n_id = 0;
    int   n_byp = 0;
    bit   done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic drive(input logic v, input logic b, input logic e);
        @(negedge clk);
        bit_valid     = v;
        bit_in        = b;
        end_of_stream = e;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 1'b0);
    endtask

    task automatic send_bypass(input logic e);
        exp_t x;
        x.kind = 0;
        x.code = '0;
        exp_q.push_back(x);
        n_byp++;
        drive(1'b1, 1'b0, e);
    endtask

    // R5: gap cycles carry noise on bit_in with bit_valid low
    task automatic send_id(input logic [31:0] code, input bit gaps, input logic e_last);
        exp_t x;
        x.kind = 1;
        x.code = code;
        exp_q.push_back(x);
        n_id++;
        for (int i = 0; i < 32; i++) begin
            drive(1'b1, code[i], (i == 31) ? e_last : 1'b0);
            if (gaps && (i % 3 == 1) && i != 31) drive(1'b0, ~code[i], 1'b0);
        end
    endtask

    // R6: partial code followed by end of stream
    task automatic send_trunc(input logic [31:0] code, input int nbits, input bit eos_on_bit);
        exp_t x;
        x.kind = 2;
        x.code = '0;
        exp_q.push_back(x);
        for (int i = 0; i < nbits; i++) begin
            drive(1'b1, code[i], (eos_on_bit && i == nbits - 1) ? 1'b1 : 1'b0);
        end
        if (!eos_on_bit) drive(1'b0, 1'b0, 1'b1);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done && (out_valid || out_trunc_err)) begin
            chk(!(out_valid && out_trunc_err), "R9", "valid and trunc together",
                {30'd0, out_valid, out_trunc_err}, 32'd0);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7", "unexpected output",
                    {30'd0, out_valid, out_trunc_err}, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.kind == 2) begin
                    chk(out_trunc_err && !out_valid, "R6", "truncation pulse",
                        {30'd0, out_valid, out_trunc_err}, 32'd1);
                end else if (e.kind == 0) begin
                    chk(out_valid && !out_has_idcode, "R2", "bypass record",
                        {30'd0, out_valid, out_has_idcode}, 32'd2);
                    chk(out_idcode == 0 && out_version == 0 && out_part == 0 &&
                        out_bank == 0 && out_mfr_id == 0, "R10", "bypass fields zero",
                        out_idcode, 32'd0);
                end else begin
                    chk(out_valid && out_has_idcode, "R3", "code record flags",
                        {30'd0, out_valid, out_has_idcode}, 32'd3);
                    chk(out_idcode == e.code, "R3", "assembled code", out_idcode, e.code);
                    chk(out_version == e.code[31:28], "R4", "version",
                        {28'd0, out_version}, {28'd0, e.code[31:28]});
                    chk(out_part == e.code[27:12], "R4", "part",
                        {16'd0, out_part}, {16'd0, e.code[27:12]});
                    chk(out_bank == e.code[11:8], "R4", "bank",
                        {28'd0, out_bank}, {28'd0, e.code[11:8]});
                    chk(out_mfr_id == e.code[7:1], "R4", "mfr id",
                        {25'd0, out_mfr_id}, {25'd0, e.code[7:1]});
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog all actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(!out_valid && !out_trunc_err, "R1", "strobes after reset",
            {30'd0, out_valid, out_trunc_err}, 32'd0);
        chk(rec_count == 0 && id_count == 0 && byp_count == 0, "R1", "counts after reset",
            32'(rec_count), 32'd0);

        send_bypass(1'b0);
        send_id(32'h4BA0_0477, 1'b0, 1'b0);
        send_bypass(1'b0);
        send_bypass(1'b0);
        send_id(32'hFFFF_FFFF, 1'b0, 1'b0);
        send_id(32'h8000_0001, 1'b1, 1'b0);          // R5 gaps with noise
        idle(3);
        drive(1'b0, 1'b1, 1'b1);                       // R7 end while idle
        idle(3);
        send_id(32'h0362_D093, 1'b1, 1'b1);            // R7 end on last bit
        idle(2);
        send_trunc(32'h1234_5679, 10, 1'b0);           // R6 end on own cycle
        send_id(32'h1234_5679, 1'b0, 1'b0);            // R6 restart
        send_trunc(32'h0000_0001, 1, 1'b1);            // R6 end on start bit
        send_trunc(32'h7654_3211, 31, 1'b1);           // R6 end on 31st bit
        send_bypass(1'b1);                             // R7 end with bypass bit
        send_id(32'hA5C3_0F0F, 1'b0, 1'b0);
        idle(5);

        chk(exp_q.size() == 0, "R3", "records outstanding", 32'(exp_q.size()), 32'd0);
        chk(32'(id_count) == n_id, "R8", "id_count", 32'(id_count), 32'(n_id));
        chk(32'(byp_count) == n_byp, "R8", "byp_count", 32'(byp_count), 32'(n_byp));
        chk(32'(rec_count) == n_id + n_byp, "R8", "rec_count",
            32'(rec_count), 32'(n_id + n_byp));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule